// File: doc/BRIEF.md
# Multiplexed Nibble Register Bus Slave

This block lets an external host reach a small bank of 16-bit registers over a narrow, low-speed bus. Address and data share one 4-bit bus and are separated in time. The host first sets the register address with pulses of an address-latch strobe. It then moves data one nibble per pulse of an active-low read or write strobe. All strobes only take effect while the active-low select is asserted.

Each read word comes from a shadow copy. The copy is taken when the first nibble of the word is read, so a hardware update to the register during the read cannot give the host a mix of old and new nibbles. A host write is collected nibble by nibble and reaches the bank only when the last nibble is done. On the core side there are these connections:
- a write port that hardware uses to update registers;
- a flat view of the whole bank;
- an event input that raises an active-low interrupt, which the host clears by writing to a dedicated acknowledge address.

The bus pins are split into an input nibble, an output nibble and an output enable. A pad ring combines these into the bidirectional wires. The strobes are sampled by the block clock, which is assumed to be several times faster than the strobe widths.

Top module: `nbs_slave`

## Requirements
- R1: After reset, `bus_oe` is 0, `irq_n` is 1 and every bank register reads 0.
- R2: The register address is 12 bits. It is shifted in one nibble on each falling edge of `ale`, most significant nibble first, using the bus value present while `ale` was high. Only the last three nibbles sent count.
- R3: A write word is four nibbles, most significant first. One nibble is taken from `bus_i` at each rising edge of `wr_n`. The bank register changes only after the fourth nibble; after three nibbles it still holds its old value.
- R4: A read returns the addressed register as four nibbles on `bus_o`, most significant first, one per low pulse of `rd_n`.
- R5: The read word is copied when its first nibble is read. A core update to that register during the read does not change the remaining three nibbles. The next read returns the updated value.
- R6: `bus_oe` is 1 only while select and the read strobe are both low. It rises within 2 clock cycles after `rd_n` falls and drops within 2 clock cycles after `rd_n` rises.
- R7: While `cs_n` is high, `ale`, `rd_n` and `wr_n` have no effect: the address, the bank contents and `bus_oe` stay unchanged.
- R8: Addresses at or above the bank size (8 registers, index = address bits [2:0]) that are not the acknowledge address read as 16'h0000. Writes to them change no register.
- R9: A pulse on `core_evt` makes `irq_n` go low. Reading address 12'hFFF returns the pending flag in bit 0. Writing any word to 12'hFFF sets `irq_n` back to 1. If an event arrives in the same cycle as the acknowledge commit, the event wins and `irq_n` stays low.
- R10: A falling edge of `ale` restarts the data-nibble sequence. A write left incomplete before a new address is dropped, and the next four nibbles form a fresh word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select qualifying all strobes |
| ale | input | 1 | Address-latch strobe, address nibble taken on its falling edge |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe, nibble taken on its rising edge |
| bus_i | input | 4 | Nibble arriving from the shared bus |
| bus_o | output | 4 | Read nibble driven toward the shared bus |
| bus_oe | output | 1 | Enable for driving `bus_o` onto the shared bus |
| irq_n | output | 1 | Active-low interrupt to the host |
| core_we | input | 1 | Hardware write enable into the bank |
| core_idx | input | 3 | Register index of the hardware write |
| core_wdata | input | 16 | Hardware write data |
| core_evt | input | 1 | Event pulse that sets the pending interrupt |
| regs_o | output | 128 | Whole bank flattened, register i at bits [16*i+15:16*i] |

## Verification
Some rules hold on every cycle and are checked by assertions:
- the output enable only follows a selected, active read strobe;
- the shadow copy never changes in the middle of a word;
- a commit only follows a write-strobe edge;
- the nibble counter is restarted after an address strobe;
- a register holds its value unless a write targets it;
- the interrupt obeys its set and clear priority.

Other behaviour needs the bench's scenarios. These are the nibble ordering of full address and data transfers, and the dropping of a partial write. They also cover the tear-free read while the core updates the register, the decoding of out-of-range and acknowledge addresses, and the event-versus-acknowledge race timed to the exact commit cycle.

// File: rtl/nbs_pkg.sv
`timescale 1ns/1ps
package nbs_pkg;

    // Qualified strobe events seen by the sequencer, one cycle after sampling
    typedef struct packed {
        logic sel;       // select sampled active
        logic rd_act;    // select and read strobe both sampled active
        logic ale_fall;  // address strobe ended while selected
        logic rd_fall;   // read strobe started while selected
        logic rd_rise;   // read strobe ended while selected
        logic wr_rise;   // write strobe ended while selected
    } nbs_evt_t;

endpackage

// File: rtl/nbs_sync.sv
`timescale 1ns/1ps
module nbs_sync
    import nbs_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             ale,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [NIB_W-1:0] bus_i,
    output nbs_evt_t         ev_o,
    output logic [NIB_W-1:0] bus_p_o
);

    typedef struct packed {
        logic             cs_s;
        logic             ale_s;
        logic             rd_s;
        logic             wr_s;
        logic             ale_p;
        logic             rd_p;
        logic             wr_p;
        logic [NIB_W-1:0] bus_s;
        logic [NIB_W-1:0] bus_p;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.cs_s  = cs_n;
        st_d.ale_s = ale;
        st_d.rd_s  = rd_n;
        st_d.wr_s  = wr_n;
        st_d.bus_s = bus_i;
        st_d.ale_p = st_q.ale_s;
        st_d.rd_p  = st_q.rd_s;
        st_d.wr_p  = st_q.wr_s;
        st_d.bus_p = st_q.bus_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cs_s: 1'b1, ale_s: 1'b0, rd_s: 1'b1, wr_s: 1'b1,
                      ale_p: 1'b0, rd_p: 1'b1, wr_p: 1'b1,
                      bus_s: '0, bus_p: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ev_o.sel      = ~st_q.cs_s;
        ev_o.rd_act   = ~st_q.cs_s & ~st_q.rd_s;
        ev_o.ale_fall = ~st_q.cs_s &  st_q.ale_p & ~st_q.ale_s;
        ev_o.rd_fall  = ~st_q.cs_s &  st_q.rd_p  & ~st_q.rd_s;
        ev_o.rd_rise  = ~st_q.cs_s & ~st_q.rd_p  &  st_q.rd_s;
        ev_o.wr_rise  = ~st_q.cs_s & ~st_q.wr_p  &  st_q.wr_s;
    end

    // Bus value captured one sample before the edge, while the strobe was still held
    assign bus_p_o = st_q.bus_p;

    // R7: a read-start event needs select and read strobe low at the previous sample
    a_r7_rd_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
        ev_o.rd_fall |-> $past(!cs_n && !rd_n));

    // R7: a write-end event needs select low at the previous sample
    a_r7_wr_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
        ev_o.wr_rise |-> $past(!cs_n && wr_n));

endmodule

// File: rtl/nbs_seq.sv
`timescale 1ns/1ps
module nbs_seq
    import nbs_pkg::*;
#(
    parameter int NIB_W  = 4,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  nbs_evt_t          ev,
    input  logic [NIB_W-1:0]  bus_p,
    input  logic [DATA_W-1:0] bank_word,
    output logic [ADDR_W-1:0] addr_o,
    output logic [NIB_W-1:0]  out_nib_o,
    output logic              oe_o,
    output logic              commit_o,
    output logic [DATA_W-1:0] wdata_o
);

    localparam int DNIBS = DATA_W / NIB_W;
    localparam int CNT_W = (DNIBS > 1) ? $clog2(DNIBS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DNIBS - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] shadow;
        logic [NIB_W-1:0]  out;
        logic              oe;
        logic              commit;
    } seq_t;

    seq_t st_d, st_q;

    function automatic logic [NIB_W-1:0] nib_of(input logic [DATA_W-1:0] w,
                                                input logic [CNT_W-1:0] idx);
        logic [DATA_W-1:0] sh;
        sh = w >> (NIB_W * (DNIBS - 1 - int'(idx)));
        return sh[NIB_W-1:0];
    endfunction

    always_comb begin
        st_d        = st_q;
        st_d.commit = 1'b0;
        st_d.oe     = ev.rd_act;
        if (ev.ale_fall) begin
            st_d.addr = {st_q.addr[ADDR_W-NIB_W-1:0], bus_p};
            st_d.cnt  = '0;
        end else if (ev.rd_fall) begin
            if (st_q.cnt == '0) begin
                st_d.shadow = bank_word;
                st_d.out    = nib_of(bank_word, '0);
            end else begin
                st_d.out    = nib_of(st_q.shadow, st_q.cnt);
            end
        end else if (ev.rd_rise) begin
            st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + 1'b1;
        end else if (ev.wr_rise) begin
            st_d.wdata = {st_q.wdata[DATA_W-NIB_W-1:0], bus_p};
            if (st_q.cnt == LAST) begin
                st_d.commit = 1'b1;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt    = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o    = st_q.addr;
    assign out_nib_o = st_q.out;
    assign oe_o      = st_q.oe;
    assign commit_o  = st_q.commit;
    assign wdata_o   = st_q.wdata;

    // R5: the snapshot only changes when a word read begins
    a_r5_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.shadow) |-> ($past(st_q.cnt) == '0));

    // R3: a commit is always the result of a write strobe end
    a_r3_commit_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.commit |-> $past(ev.wr_rise));

    // R10: an address strobe restarts the nibble sequence
    a_r10_ale_restart: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ev.ale_fall) |-> (st_q.cnt == '0));

endmodule

// File: rtl/nbs_bank.sv
`timescale 1ns/1ps
module nbs_bank #(
    parameter int DATA_W = 16,
    parameter int NREG   = 8,
    parameter int IDX_W  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_we,
    input  logic [IDX_W-1:0]       host_idx,
    input  logic [DATA_W-1:0]      host_data,
    input  logic                   core_we,
    input  logic [IDX_W-1:0]       core_idx,
    input  logic [DATA_W-1:0]      core_data,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [DATA_W-1:0]      rd_word,
    output logic [NREG*DATA_W-1:0] regs_o
);

    logic [DATA_W-1:0] regs_d [NREG];
    logic [DATA_W-1:0] regs_q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        // Hardware updates take priority over a host commit to the same register
        always_comb begin
            regs_d[i] = regs_q[i];
            if (core_we && core_idx == IDX_W'(i)) begin
                regs_d[i] = core_data;
            end else if (host_we && host_idx == IDX_W'(i)) begin
                regs_d[i] = host_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[i] <= '0;
            end else begin
                regs_q[i] <= regs_d[i];
            end
        end

        assign regs_o[i*DATA_W +: DATA_W] = regs_q[i];

        // R3: a register holds its value unless a write targets it
        a_r3_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!(host_we && host_idx == IDX_W'(i)) && !(core_we && core_idx == IDX_W'(i)))
            |=> $stable(regs_q[i]));
    end

    assign rd_word = regs_q[rd_idx];

endmodule

// File: rtl/nbs_irq.sv
`timescale 1ns/1ps
module nbs_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic ack,
    output logic irq_n
);

    typedef struct packed {
        logic pend;
    } irq_t;

    irq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (evt) begin
            st_d.pend = 1'b1;
        end else if (ack) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_n = ~st_q.pend;

    // R9: an event always leaves the interrupt asserted, even against an acknowledge
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !irq_n);

    // R9: an acknowledge without a concurrent event releases the line
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !evt) |=> irq_n);

endmodule

// File: rtl/nbs_slave.sv
`timescale 1ns/1ps
module nbs_slave
    import nbs_pkg::*;
#(
    parameter int                NIB_W    = 4,
    parameter int                ADDR_W   = 12,
    parameter int                DATA_W   = 16,
    parameter int                NREG     = 8,
    parameter logic [ADDR_W-1:0] ACK_ADDR = '1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cs_n,
    input  logic                            ale,
    input  logic                            rd_n,
    input  logic                            wr_n,
    input  logic [NIB_W-1:0]                bus_i,
    output logic [NIB_W-1:0]                bus_o,
    output logic                            bus_oe,
    output logic                            irq_n,
    input  logic                            core_we,
    input  logic [$clog2(NREG)-1:0]         core_idx,
    input  logic [DATA_W-1:0]               core_wdata,
    input  logic                            core_evt,
    output logic [NREG*DATA_W-1:0]          regs_o
);

    localparam int IDX_W = $clog2(NREG);

    nbs_evt_t          ev;
    logic [NIB_W-1:0]  bus_p;
    logic [ADDR_W-1:0] addr;
    logic              commit;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] bank_rd;
    logic [DATA_W-1:0] word_sel;
    logic              in_range;
    logic              is_ack;
    logic              host_we;
    logic              ack;

    nbs_sync #(.NIB_W(NIB_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .ale     (ale),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .bus_i   (bus_i),
        .ev_o    (ev),
        .bus_p_o (bus_p)
    );

    nbs_seq #(.NIB_W(NIB_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .bus_p     (bus_p),
        .bank_word (word_sel),
        .addr_o    (addr),
        .out_nib_o (bus_o),
        .oe_o      (bus_oe),
        .commit_o  (commit),
        .wdata_o   (wdata)
    );

    // Address decode: bank window, acknowledge address, everything else reads zero
    always_comb begin
        in_range = (addr < ADDR_W'(NREG));
        is_ack   = (addr == ACK_ADDR);
        host_we  = commit & in_range;
        ack      = commit & is_ack;
        if (is_ack) begin
            word_sel = {{(DATA_W-1){1'b0}}, ~irq_n};
        end else if (in_range) begin
            word_sel = bank_rd;
        end else begin
            word_sel = '0;
        end
    end

    nbs_bank #(.DATA_W(DATA_W), .NREG(NREG), .IDX_W(IDX_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (host_we),
        .host_idx  (addr[IDX_W-1:0]),
        .host_data (wdata),
        .core_we   (core_we),
        .core_idx  (core_idx),
        .core_data (core_wdata),
        .rd_idx    (addr[IDX_W-1:0]),
        .rd_word   (bank_rd),
        .regs_o    (regs_o)
    );

    nbs_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (core_evt),
        .ack   (ack),
        .irq_n (irq_n)
    );

    // R6: the bus is only driven two samples after select and read strobe were low
    a_r6_oe_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> $past(!cs_n && !rd_n, 2));

    // R8: a host commit outside the bank never reaches a register
    a_r8_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !in_range && !core_we) |=> $stable(regs_o));

endmodule

// File: tb/nbs_slave_tb.sv
`timescale 1ns/1ps
module nbs_slave_tb;

    localparam int NREG = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1, ale = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic [3:0]   bus_i = '0;
    logic [3:0]   bus_o;
    logic         bus_oe, irq_n;
    logic         core_we = 1'b0, core_evt = 1'b0;
    logic [2:0]   core_idx = '0;
    logic [15:0]  core_wdata = '0;
    logic [127:0] regs_o;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 1'b0;
    logic [15:0] exp_regs [NREG];

    logic [3:0] exp_q [$];
    string      tag_q [$];
    logic       oe_prev = 1'b0;

    always #10 clk = ~clk;

    nbs_slave u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe), .irq_n(irq_n),
        .core_we(core_we), .core_idx(core_idx), .core_wdata(core_wdata),
        .core_evt(core_evt), .regs_o(regs_o)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] reg_of(input int i);
        return regs_o[i*16 +: 16];
    endfunction

    task automatic check_bank(input string tag);
        for (int i = 0; i < NREG; i++) check(reg_of(i) == exp_regs[i], tag, reg_of(i), exp_regs[i]);
    endtask

    // Scoreboard monitor: compare each newly driven nibble against the queue
    always @(negedge clk) begin
        if (bus_oe && !oe_prev) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected drive", {28'h0, bus_o}, 32'h0);
            end else begin
                logic [3:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(bus_o == e, t, {28'h0, bus_o}, {28'h0, e});
            end
        end
        oe_prev <= bus_oe;
    end

    task automatic ale_nib(input logic [3:0] n);
        bus_i = n; ale = 1'b1; tick(3);
        ale = 1'b0; tick(3);
    endtask

    task automatic send_addr(input logic [11:0] a);
        for (int k = 2; k >= 0; k--) ale_nib(a[k*4 +: 4]);
    endtask

    task automatic wr_nib(input logic [3:0] n, input bit evt_at_commit);
        bus_i = n; wr_n = 1'b0; tick(3);
        wr_n = 1'b1;
        if (evt_at_commit) begin
            tick(2); core_evt = 1'b1; tick(1); core_evt = 1'b0; tick(1);
        end else begin
            tick(4);
        end
    endtask

    task automatic wr_word(input logic [15:0] w);
        for (int k = 3; k >= 0; k--) wr_nib(w[k*4 +: 4], 1'b0);
    endtask

    task automatic rd_nib(input logic [3:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        rd_n = 1'b0; tick(2);
        check(bus_oe == 1'b1, "R6 drive within 2 cycles", {31'h0, bus_oe}, 32'h1);
        tick(1);
        rd_n = 1'b1; tick(2);
        check(bus_oe == 1'b0, "R6 release within 2 cycles", {31'h0, bus_oe}, 32'h0);
        tick(1);
    endtask

    task automatic rd_word(input logic [15:0] w, input string tag);
        for (int k = 3; k >= 0; k--) rd_nib(w[k*4 +: 4], tag);
    endtask

    task automatic core_write(input int idx, input logic [15:0] v);
        core_we = 1'b1; core_idx = 3'(idx); core_wdata = v; tick(1);
        core_we = 1'b0; tick(1);
        exp_regs[idx] = v;
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        summary();
    end

    initial begin
        for (int i = 0; i < NREG; i++) exp_regs[i] = '0;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        check(bus_oe == 1'b0, "R1 bus_oe", {31'h0, bus_oe}, 32'h0);
        check(irq_n == 1'b1, "R1 irq_n", {31'h0, irq_n}, 32'h1);
        check(regs_o == '0, "R1 bank zero", regs_o[31:0], 32'h0);
        cs_n = 1'b0; tick(2);

        // R2 / R3: write register 3
        send_addr(12'h003); wr_word(16'hA5C3); exp_regs[3] = 16'hA5C3;
        check_bank("R3 full write");
        // R4 read back
        rd_word(16'hA5C3, "R4 read nibble");

        // R2: four address nibbles, last three count -> 0x005
        ale_nib(4'h1); ale_nib(4'h0); ale_nib(4'h0); ale_nib(4'h5);
        wr_word(16'h1234); exp_regs[5] = 16'h1234;
        check_bank("R2 last three nibbles");

        // R3: no commit before the fourth nibble
        send_addr(12'h006);
        wr_nib(4'h9, 1'b0); wr_nib(4'h8, 1'b0); wr_nib(4'h7, 1'b0);
        check(reg_of(6) == 16'h0, "R3 partial write held", reg_of(6), 16'h0);
        wr_nib(4'h6, 1'b0); exp_regs[6] = 16'h9876;
        check(reg_of(6) == 16'h9876, "R3 commit on fourth", reg_of(6), 16'h9876);

        // R10: new address drops an incomplete write
        send_addr(12'h007); wr_nib(4'hF, 1'b0); wr_nib(4'hF, 1'b0);
        send_addr(12'h007); wr_word(16'h0102); exp_regs[7] = 16'h0102;
        check_bank("R10 restart after ale");

        // R7: strobes ignored while deselected
        cs_n = 1'b1; tick(2);
        send_addr(12'h003); wr_word(16'hFFFF);
        rd_n = 1'b0; tick(3);
        check(bus_oe == 1'b0, "R7 no drive when deselected", {31'h0, bus_oe}, 32'h0);
        rd_n = 1'b1; tick(3);
        cs_n = 1'b0; tick(2);
        check_bank("R7 bank unchanged");
        rd_word(16'h0102, "R7 address kept");

        // R8: out-of-range address
        send_addr(12'h040); wr_word(16'hBEEF);
        check_bank("R8 stray write ignored");
        rd_word(16'h0000, "R8 reads zero");

        // R5: tear-free read during a core update
        send_addr(12'h003);
        rd_nib(4'hA, "R5 first nibble");
        core_write(3, 16'h1111);
        rd_nib(4'h5, "R5 snapshot"); rd_nib(4'hC, "R5 snapshot"); rd_nib(4'h3, "R5 snapshot");
        check(reg_of(3) == 16'h1111, "R5 core update landed", reg_of(3), 16'h1111);
        rd_word(16'h1111, "R5 next read new");

        // R9: interrupt set, status read, acknowledge
        core_evt = 1'b1; tick(1); core_evt = 1'b0; tick(1);
        check(irq_n == 1'b0, "R9 event asserts", {31'h0, irq_n}, 32'h0);
        send_addr(12'hFFF);
        rd_word(16'h0001, "R9 status pending");
        wr_word(16'h0000);
        check(irq_n == 1'b1, "R9 ack clears", {31'h0, irq_n}, 32'h1);
        rd_word(16'h0000, "R9 status clear");
        check_bank("R9 ack touches no register");
        // R9: event in the commit cycle of an acknowledge wins
        wr_nib(4'h0, 1'b0); wr_nib(4'h0, 1'b0); wr_nib(4'h0, 1'b0); wr_nib(4'h0, 1'b1);
        check(irq_n == 1'b0, "R9 event beats ack", {31'h0, irq_n}, 32'h0);
        wr_word(16'h0000);
        check(irq_n == 1'b1, "R9 second ack clears", {31'h0, irq_n}, 32'h1);

        tick(4);
        check(exp_q.size() == 0, "R4 all reads observed", exp_q.size(), 32'h0);
        summary();
    end

endmodule